// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block sits between a memory controller's command/address bus and a bank of memory devices. On each rising clock edge it captures an input word and presents it on a registered output word. A two-bit configuration input picks one of two layouts. In the wide layout, every input bit drives one output bit. In the paired layout, fourteen selected input bits each drive two output copies, so one captured bit can serve two loads.

In the paired layout, one configuration bit picks which half of a module pair the device serves. The first register of the pair takes the low input lanes and the second takes the high lanes. Two active-low chip selects gate the capture. When neither is asserted, the outputs keep their value and do not toggle. An asynchronous active-low reset clears the output word.

The data path is a fixed one-stage pipeline. There is no valid/ready handshake and no back-pressure: a word is accepted on every edge at which a chip select is asserted. The chip selects are the only way to hold the outputs.

Top module: `cmdbuf_top`

## Requirements
- R1: With cfg[0]=0 (wide layout), q[24:0] equals the d[24:0] sampled at a rising edge, starting just after that edge.
- R2: With cfg[0]=1 (paired layout), the 14 captured bits appear twice: on q[13:0] and, bit for bit, on q[27:14].
- R3: With cfg=2'b01 (first register of a pair), the captured lanes are d[13:0], so q[i] and q[14+i] both equal d[i].
- R4: With cfg=2'b11 (second register of a pair), the captured lanes are d[24:11], so q[i] and q[14+i] both equal d[11+i].
- R5: In the wide layout, the output bits above the wide width, q[27:25], are driven to zero.
- R6: When cs_n=2'b11 at a rising edge, q does not change, whatever d and cfg hold.
- R7: Asserting either chip select alone (cs_n=2'b10 or 2'b01) is enough for a capture at that edge.
- R8: rst_n=0 drives q to all zeros at once, without a clock. After release, q stays zero until the first rising edge at which a chip select is asserted.
- R9: A change of cfg takes effect at the next rising edge at which a chip select is asserted. The output does not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg | input | 2 | Layout select: bit 0 chooses paired layout, bit 1 chooses second register of a pair |
| cs_n | input | 2 | Chip selects, active low; a capture takes place when either is low |
| d | input | 25 | Command/address input word |
| q | output | 28 | Registered output word |

## Verification
Two functions can meet in the same edge: a layout change and a held edge, or a layout change and the return of reset. The bench switches cfg on cycles with both chip selects high, and it also switches cfg while reset is still held. It then checks that q keeps its old value or stays zero. The new layout must appear only on the first enabled edge. Random d, cfg and cs_n are also run against a behavioural model, so layout changes fall directly on capturing edges and hold edges alike, and each cycle is compared.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

  typedef enum logic [1:0] {
    LAYOUT_WIDE   = 2'd0,
    LAYOUT_PAIR_A = 2'd1,
    LAYOUT_PAIR_B = 2'd2
  } layout_e;

  function automatic layout_e decode_layout(input logic [1:0] cfg_in);
    if (!cfg_in[0])     return LAYOUT_WIDE;
    else if (cfg_in[1]) return LAYOUT_PAIR_B;
    else                return LAYOUT_PAIR_A;
  endfunction

endpackage

// File: rtl/cmdbuf_decode.sv
module cmdbuf_decode
  import cmdbuf_pkg::*;
(
  input  logic [1:0] cfg,
  input  logic [1:0] cs_n,
  output layout_e    layout,
  output logic       capture
);
  always_comb begin
    layout  = decode_layout(cfg);
    capture = ~(&cs_n);
  end
endmodule

// File: rtl/cmdbuf_route.sv
module cmdbuf_route
  import cmdbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  layout_e                  layout,
  input  logic [WIDE_W-1:0]        d,
  output logic [((WIDE_W > 2*NARROW_W) ? WIDE_W : 2*NARROW_W)-1:0] nxt
);
  localparam int OUT_W  = (WIDE_W > 2*NARROW_W) ? WIDE_W : 2*NARROW_W;
  localparam int B_BASE = WIDE_W - NARROW_W;

  for (genvar g = 0; g < OUT_W; g++) begin : g_bit
    logic wide_bit;
    logic pair_a_bit;
    logic pair_b_bit;

    if (g < WIDE_W) begin : g_wide
      assign wide_bit = d[g];
    end else begin : g_wide_pad
      assign wide_bit = 1'b0;
    end

    if (g < 2*NARROW_W) begin : g_pair
      assign pair_a_bit = d[g % NARROW_W];
      assign pair_b_bit = d[B_BASE + (g % NARROW_W)];
    end else begin : g_pair_pad
      assign pair_a_bit = 1'b0;
      assign pair_b_bit = 1'b0;
    end

    always_comb begin
      unique case (layout)
        LAYOUT_PAIR_A: nxt[g] = pair_a_bit;
        LAYOUT_PAIR_B: nxt[g] = pair_b_bit;
        default:       nxt[g] = wide_bit;
      endcase
    end
  end
endmodule

// File: rtl/cmdbuf_stage.sv
module cmdbuf_stage #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/cmdbuf_top.sv
module cmdbuf_top
  import cmdbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  localparam int OUT_W   = (WIDE_W > 2*NARROW_W) ? WIDE_W : 2*NARROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg,
  input  logic [1:0]        cs_n,
  input  logic [WIDE_W-1:0] d,
  output logic [OUT_W-1:0]  q
);
  layout_e            layout;
  logic               capture;
  logic [OUT_W-1:0]   nxt;

  cmdbuf_decode u_decode (
    .cfg     (cfg),
    .cs_n    (cs_n),
    .layout  (layout),
    .capture (capture)
  );

  cmdbuf_route #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_route (
    .layout (layout),
    .d      (d),
    .nxt    (nxt)
  );

  cmdbuf_stage #(.W(OUT_W)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (capture),
    .nxt   (nxt),
    .q     (q)
  );
endmodule

// File: rtl/cmdbuf_chk.sv
module cmdbuf_chk #(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  localparam int OUT_W   = (WIDE_W > 2*NARROW_W) ? WIDE_W : 2*NARROW_W,
  localparam int B_BASE  = WIDE_W - NARROW_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg,
  input logic [1:0]        cs_n,
  input logic [WIDE_W-1:0] d,
  input logic [OUT_W-1:0]  q
);
  logic cap;
  assign cap = (cs_n != 2'b11);

  // R1 / R9: wide capture shows the sampled word
  p_wide_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !cfg[0]) |=> q[WIDE_W-1:0] == $past(d));

  // R2: paired copies agree
  p_pair_dup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && cfg[0]) |=> q[NARROW_W-1:0] == q[2*NARROW_W-1:NARROW_W]);

  // R3: first register of a pair takes low lanes
  p_pair_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && cfg == 2'b01) |=> q[NARROW_W-1:0] == $past(d[NARROW_W-1:0]));

  // R4: second register of a pair takes high lanes
  p_pair_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && cfg == 2'b11) |=> q[NARROW_W-1:0] == $past(d[WIDE_W-1:B_BASE]));

  // R5: pad bits zero in wide layout
  if (OUT_W > WIDE_W) begin : g_pad_chk
    p_wide_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !cfg[0]) |=> q[OUT_W-1:WIDE_W] == '0);
  end

  // R6: no chip select means no output change
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == 2'b11) |=> $stable(q));

  // R8: reset holds outputs at zero
  always @(posedge clk) begin
    if (!rst_n) p_reset_clear_r8: assert (q == '0);
  end
endmodule

bind cmdbuf_top cmdbuf_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .cs_n(cs_n), .d(d), .q(q)
);

// File: tb/cmdbuf_top_tb_top.sv
`timescale 1ns/1ps
module cmdbuf_top_tb_top;
  localparam int WW = 25;
  localparam int NW = 14;
  localparam int OW = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg = 2'b00;
  logic [1:0]    cs_n = 2'b11;
  logic [WW-1:0] d = '0;
  logic [OW-1:0] q;

  logic [OW-1:0] exp_q = '0;
  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cmdbuf_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cs_n(cs_n), .d(d), .q(q)
  );

  function automatic logic [OW-1:0] model(input logic [1:0] c, input logic [WW-1:0] dv);
    logic [OW-1:0] m = '0;
    int base;
    if (c[0] == 1'b0) begin
      for (int i = 0; i < WW; i++) m[i] = dv[i];
    end else begin
      base = c[1] ? (WW - NW) : 0;
      for (int i = 0; i < NW; i++) begin
        m[i]      = dv[base + i];
        m[NW + i] = dv[base + i];
      end
    end
    return m;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (q !== exp_q) begin
      bad++;
      $display("FAIL %s: q=%h expected=%h", tag, q, exp_q);
    end
  endtask

  task automatic cycle(input logic [1:0] c, input logic [1:0] cs,
                       input logic [WW-1:0] dv, input string tag);
    cfg = c; cs_n = cs; d = dv;
    @(posedge clk);
    if (rst_n && cs != 2'b11) exp_q = model(c, dv);
    @(negedge clk);
    check(tag);
  endtask

  function automatic string tag_for(input logic [1:0] c, input logic [1:0] cs);
    if (cs == 2'b11)     return "R6 hold";
    if (c[0] == 1'b0)    return "R1 R5 wide";
    if (c[1] == 1'b0)    return "R2 R3 pair first";
    return "R2 R4 pair second";
  endfunction

  initial begin
    #4_000_000;
    if (!finished) begin
      bad++;
      checks++;
      $display("FAIL watchdog: expected=finish actual=hang");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R8 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    // R8: stays zero after release with held edge
    cycle(2'b00, 2'b11, 25'h1FFFFFF, "R8 zero until enabled edge");
    cycle(2'b00, 2'b00, 25'h1ABCDEF, "R1 R5 wide all-cs");
    cycle(2'b00, 2'b10, 25'h0F0F0F0, "R7 cs0 only");
    cycle(2'b00, 2'b01, 25'h1234567, "R7 cs1 only");
    cycle(2'b01, 2'b00, 25'h0003FFF, "R3 pair first low lanes");
    cycle(2'b01, 2'b00, 25'h1FFC000, "R3 pair first ignores high");
    cycle(2'b11, 2'b00, 25'h1FFF800, "R4 pair second high lanes");
    cycle(2'b11, 2'b00, 25'h00007FF, "R4 pair second ignores low");
    cycle(2'b10, 2'b00, 25'h1555555, "R1 cfg[1] ignored in wide");
    // R9: config change on held edges must not disturb q
    cycle(2'b11, 2'b11, 25'h0AAAAAA, "R9 R6 cfg change held");
    cycle(2'b01, 2'b11, 25'h1FFFFFF, "R9 R6 cfg change held again");
    cycle(2'b01, 2'b10, 25'h0000ABC, "R9 new layout on enabled edge");
    // R8: async reset mid-run
    #3 rst_n = 1'b0;
    #2 exp_q = '0;
    check("R8 async clear");
    cfg = 2'b11;
    @(negedge clk);
    check("R8 held in reset");
    rst_n = 1'b1;
    cycle(2'b11, 2'b11, 25'h1FFFFFF, "R8 R9 zero after release");
    cycle(2'b11, 2'b01, 25'h1FFFFFF, "R4 first enabled after reset");
    for (int n = 0; n < 400; n++) begin
      logic [1:0] c;
      logic [1:0] cs;
      logic [WW-1:0] dv;
      c  = 2'($urandom_range(0, 3));
      cs = 2'($urandom_range(0, 3));
      dv = WW'($urandom);
      cycle(c, cs, dv, tag_for(c, cs));
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule